// File: doc/BRIEF.md
# CCD Line-Region Blanking Sequencer

This block drives the per-pixel horizontal control strobes of a CCD readout path. It has three strobes: a shift-blanking strobe for the horizontal transfer gap, a data-blanking strobe that marks pixels carrying no usable data, and a black-clamp strobe that tells the clamp loop when optical-black pixels are present. It counts lines from the frame sync and pixel positions from the line sync. For each line it picks one of three horizontal sequences from the line's vertical position: vertical blanking, vertical black lines, or image lines. Each sequence has its own clamp and blanking pattern.

A line begins with a fixed number of shift clocks, followed by dummy pixels from the horizontal register, a few leading black pixels, the active pixels and a group of trailing black pixels. A frame has some blanking lines after the frame sync, then leading black lines, image lines, trailing black lines, and blanking again. Every region size is a parameter. All outputs are registered on the pixel clock, and the active sequence is also reported as a 2-bit code.

Top module: `ccd_hseq_sequencer`

## Requirements
- R1: While `rstN` is low at a clock edge, the outputs become shiftBlank=0, dataBlank=1, blackClamp=0 and seqCode=1. They hold those values until the first line sync.
- R2: A frame sync sampled high clears the line count. The k-th line sync after it (k from 1) starts line k. Lines 1..VBL_LINES are blanking lines. The next FRONT_OB_LINES lines are black lines, then IMAGE_LINES image lines, then BACK_OB_LINES black lines. Line 0 and all later lines are blanking lines. If frame sync and line sync are high in the same cycle, the frame sync wins: the line count becomes 0 and the pixel position still restarts.
- R3: seqCode takes 1 for blanking, 2 for black lines and 3 for image lines, and never 0. It takes the new line's value at the clock edge that samples the line sync high, and holds at every other edge.
- R4: If the line sync is sampled high at edge t, the strobes for pixel position p appear after edge t+1+p. shiftBlank is high exactly for positions 0..SHIFT_CLKS-1.
- R5: Over the DUMMY_PIX positions that follow the shift clocks, dataBlank is high and blackClamp is low, in every sequence.
- R6: In a blanking line, dataBlank is high at every position from SHIFT_CLKS onward and blackClamp is never high.
- R7: In a black line, blackClamp is high and dataBlank is low over the leading black, active and trailing black positions.
- R8: In an image line, blackClamp is high only over the BACK_OB_PIX trailing black positions. dataBlank is low over the leading black, active and trailing black positions.
- R9: Once the trailing black pixels have passed, and until the next line sync, dataBlank is high and the other two strobes are low.
- R10: At most one of the three strobes is high in any cycle.
- R11: A line sync that arrives before the line has finished restarts the pixel position at once. It starts the next line with no leftover strobes from the cut line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| vSync | input | 1 | Frame sync pulse, one clock wide |
| hSync | input | 1 | Line sync pulse, one clock wide |
| shiftBlank | output | 1 | Horizontal transfer blanking strobe |
| dataBlank | output | 1 | Invalid-data blanking strobe |
| blackClamp | output | 1 | Optical-black clamp strobe |
| seqCode | output | 2 | Active horizontal sequence (1 blanking, 2 black line, 3 image line) |

## Verification
The bench runs two small frames. The first covers every vertical region and the blanking lines after the frame end. A design with the line boundaries off by one would clamp a whole blanking or image line. The second frame starts with frame sync and line sync in the same cycle, which a design that lets the line sync win would number as line 1. It also cuts an image line short in the middle of its active pixels, which would show up as a stale trailing clamp if the pixel position did not restart. Idle cycles after reset and past each line's end check the tail state. Comparing every pixel catches any one-cycle shift of the clamp window against the dummy pixels.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

  typedef enum logic [1:0] {
    SEQ_NONE   = 2'd0,
    SEQ_VBLANK = 2'd1,
    SEQ_VOB    = 2'd2,
    SEQ_IMAGE  = 2'd3
  } seq_e;

  // Pixel-window flags handed from control to the strobe path; at most one set.
  typedef struct packed {
    logic inShift;
    logic inDummy;
    logic inFrontOb;
    logic inActive;
    logic inBackOb;
  } pixWin_t;

endpackage

// File: rtl/hseq_frame_ctrl.sv
module hseq_frame_ctrl
  import hseq_pkg::*;
#(
  parameter int VBL_LINES      = 4,
  parameter int FRONT_OB_LINES = 10,
  parameter int IMAGE_LINES    = 480,
  parameter int BACK_OB_LINES  = 2,
  parameter int SHIFT_CLKS     = 8,
  parameter int DUMMY_PIX      = 28,
  parameter int FRONT_OB_PIX   = 4,
  parameter int ACTIVE_PIX     = 640,
  parameter int BACK_OB_PIX    = 48
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    vSync,
  input  logic    hSync,
  output pixWin_t win,
  output seq_e    seq
);

  // Pixel-position boundaries inside a line
  localparam int W_DUM = SHIFT_CLKS;
  localparam int W_FOB = W_DUM + DUMMY_PIX;
  localparam int W_ACT = W_FOB + FRONT_OB_PIX;
  localparam int W_BOB = W_ACT + ACTIVE_PIX;
  localparam int W_END = W_BOB + BACK_OB_PIX;
  localparam int PW    = $clog2(W_END + 1);

  // Line-number boundaries inside a frame
  localparam int L_OB1 = VBL_LINES + 1;
  localparam int L_IMG = L_OB1 + FRONT_OB_LINES;
  localparam int L_OB2 = L_IMG + IMAGE_LINES;
  localparam int L_END = L_OB2 + BACK_OB_LINES;
  localparam int LW    = $clog2(L_END + 1);

  localparam logic [PW-1:0] C_DUM = PW'(W_DUM);
  localparam logic [PW-1:0] C_FOB = PW'(W_FOB);
  localparam logic [PW-1:0] C_ACT = PW'(W_ACT);
  localparam logic [PW-1:0] C_BOB = PW'(W_BOB);
  localparam logic [PW-1:0] C_END = PW'(W_END);
  localparam logic [LW-1:0] C_OB1 = LW'(L_OB1);
  localparam logic [LW-1:0] C_IMG = LW'(L_IMG);
  localparam logic [LW-1:0] C_OB2 = LW'(L_OB2);
  localparam logic [LW-1:0] C_LND = LW'(L_END);

  logic [PW-1:0] pixCnt;
  logic [LW-1:0] lineCnt;
  logic [LW-1:0] lineNext;
  seq_e          seqNext;

  // Line count: frame sync wins over a coincident line sync
  always_comb begin
    lineNext = lineCnt;
    if (vSync)
      lineNext = '0;
    else if (hSync && lineCnt != C_LND)
      lineNext = lineCnt + 1'b1;
  end

  // Vertical region of the line about to start
  always_comb begin
    if (lineNext >= C_OB1 && lineNext < C_IMG)
      seqNext = SEQ_VOB;
    else if (lineNext >= C_IMG && lineNext < C_OB2)
      seqNext = SEQ_IMAGE;
    else if (lineNext >= C_OB2 && lineNext < C_LND)
      seqNext = SEQ_VOB;
    else
      seqNext = SEQ_VBLANK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt  <= C_END;
      lineCnt <= '0;
      seq     <= SEQ_VBLANK;
    end else begin
      lineCnt <= lineNext;
      if (hSync) begin
        pixCnt <= '0;
        seq    <= seqNext;
      end else if (pixCnt != C_END) begin
        pixCnt <= pixCnt + 1'b1;
      end
    end
  end

  // Horizontal window decode of the current pixel position
  always_comb begin
    win.inShift   = (pixCnt < C_DUM);
    win.inDummy   = (pixCnt >= C_DUM) && (pixCnt < C_FOB);
    win.inFrontOb = (pixCnt >= C_FOB) && (pixCnt < C_ACT);
    win.inActive  = (pixCnt >= C_ACT) && (pixCnt < C_BOB);
    win.inBackOb  = (pixCnt >= C_BOB) && (pixCnt < C_END);
  end

  p_pix_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    hSync |=> (pixCnt == '0));

  p_line_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    vSync |=> (lineCnt == '0));

  p_seq_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !hSync |=> $stable(seq));

  p_seq_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    seq != SEQ_NONE);

  p_win_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(win));

endmodule

// File: rtl/hseq_strobe_path.sv
module hseq_strobe_path
  import hseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  pixWin_t win,
  input  seq_e    seq,
  output logic    shiftBlank,
  output logic    dataBlank,
  output logic    blackClamp
);

  logic shiftN, blankN, clampN;

  // Sequence x window -> strobe mapping
  always_comb begin
    shiftN = 1'b0;
    blankN = 1'b0;
    clampN = 1'b0;
    if (win.inShift) begin
      shiftN = 1'b1;
    end else if (win.inDummy) begin
      blankN = 1'b1;
    end else if (win.inFrontOb || win.inActive || win.inBackOb) begin
      unique case (seq)
        SEQ_VOB:   clampN = 1'b1;
        SEQ_IMAGE: clampN = win.inBackOb;
        default:   blankN = 1'b1;
      endcase
    end else begin
      blankN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBlank <= 1'b0;
      dataBlank  <= 1'b1;
      blackClamp <= 1'b0;
    end else begin
      shiftBlank <= shiftN;
      dataBlank  <= blankN;
      blackClamp <= clampN;
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({shiftBlank, dataBlank, blackClamp}) <= 1);

  p_dummy_noclamp_r5: assert property (@(posedge clk) disable iff (!rstN)
    win.inDummy |=> (dataBlank && !blackClamp));

  p_shift_win_r4: assert property (@(posedge clk) disable iff (!rstN)
    win.inShift |=> shiftBlank);

  p_vob_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seq == SEQ_VOB && (win.inFrontOb || win.inActive || win.inBackOb)) |=> blackClamp);

  p_vblank_noclamp_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seq == SEQ_VBLANK && !win.inShift) |=> (dataBlank && !blackClamp));

endmodule

// File: rtl/ccd_hseq_sequencer.sv
module ccd_hseq_sequencer
  import hseq_pkg::*;
#(
  parameter int VBL_LINES      = 4,
  parameter int FRONT_OB_LINES = 10,
  parameter int IMAGE_LINES    = 480,
  parameter int BACK_OB_LINES  = 2,
  parameter int SHIFT_CLKS     = 8,
  parameter int DUMMY_PIX      = 28,
  parameter int FRONT_OB_PIX   = 4,
  parameter int ACTIVE_PIX     = 640,
  parameter int BACK_OB_PIX    = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vSync,
  input  logic       hSync,
  output logic       shiftBlank,
  output logic       dataBlank,
  output logic       blackClamp,
  output logic [1:0] seqCode
);

  pixWin_t win;
  seq_e    seq;

  hseq_frame_ctrl #(
    .VBL_LINES     (VBL_LINES),
    .FRONT_OB_LINES(FRONT_OB_LINES),
    .IMAGE_LINES   (IMAGE_LINES),
    .BACK_OB_LINES (BACK_OB_LINES),
    .SHIFT_CLKS    (SHIFT_CLKS),
    .DUMMY_PIX     (DUMMY_PIX),
    .FRONT_OB_PIX  (FRONT_OB_PIX),
    .ACTIVE_PIX    (ACTIVE_PIX),
    .BACK_OB_PIX   (BACK_OB_PIX)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .vSync(vSync),
    .hSync(hSync),
    .win  (win),
    .seq  (seq)
  );

  hseq_strobe_path uPath (
    .clk       (clk),
    .rstN      (rstN),
    .win       (win),
    .seq       (seq),
    .shiftBlank(shiftBlank),
    .dataBlank (dataBlank),
    .blackClamp(blackClamp)
  );

  assign seqCode = seq;

endmodule

// File: tb/sim_ccd_hseq_sequencer.sv
module sim_ccd_hseq_sequencer;

  localparam int VBL = 2, FOBL = 3, IMGL = 4, BOBL = 2;
  localparam int S = 3, D = 5, FP = 2, AP = 8, BP = 4;
  localparam int WEND = S + D + FP + AP + BP;
  localparam int LEND = VBL + FOBL + IMGL + BOBL + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vSync = 1'b0;
  logic hSync = 1'b0;
  logic shiftBlank, dataBlank, blackClamp;
  logic [1:0] seqCode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string phaseTag = "";

  // reference model state
  int mPix = WEND;
  int mLine = 0;
  int mSeq = 1;
  int eZone = 5;
  int eSeqUsed = 1;
  bit eShift = 1'b0, eBlank = 1'b1, eClamp = 1'b0;

  always #2.5 clk = ~clk;

  ccd_hseq_sequencer #(
    .VBL_LINES(VBL), .FRONT_OB_LINES(FOBL), .IMAGE_LINES(IMGL), .BACK_OB_LINES(BOBL),
    .SHIFT_CLKS(S), .DUMMY_PIX(D), .FRONT_OB_PIX(FP), .ACTIVE_PIX(AP), .BACK_OB_PIX(BP)
  ) u0 (
    .clk(clk), .rstN(rstN), .vSync(vSync), .hSync(hSync),
    .shiftBlank(shiftBlank), .dataBlank(dataBlank), .blackClamp(blackClamp),
    .seqCode(seqCode)
  );

  // zone: 0 shift, 1 dummy, 2 front black, 3 active, 4 back black, 5 tail
  function automatic int zoneOf(int p);
    if (p < S) return 0;
    if (p < S + D) return 1;
    if (p < S + D + FP) return 2;
    if (p < S + D + FP + AP) return 3;
    if (p < WEND) return 4;
    return 5;
  endfunction

  function automatic int regionOf(int k);
    if (k >= 1 && k <= VBL) return 1;
    if (k > VBL && k <= VBL + FOBL) return 2;
    if (k > VBL + FOBL && k <= VBL + FOBL + IMGL) return 3;
    if (k > VBL + FOBL + IMGL && k <= VBL + FOBL + IMGL + BOBL) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPix = WEND; mLine = 0; mSeq = 1;
      eShift = 1'b0; eBlank = 1'b1; eClamp = 1'b0; eZone = 5; eSeqUsed = 1;
    end else begin
      eZone = zoneOf(mPix);
      eSeqUsed = mSeq;
      eShift = (eZone == 0);
      eBlank = (eZone == 1) || (eZone == 5) || (eZone >= 2 && eZone <= 4 && mSeq == 1);
      eClamp = (eZone >= 2 && eZone <= 4 && mSeq == 2) || (eZone == 4 && mSeq == 3);
      if (vSync) mLine = 0;
      else if (hSync && mLine < LEND) mLine = mLine + 1;
      if (hSync) begin
        mPix = 0;
        mSeq = regionOf(mLine);
      end else if (mPix < WEND) begin
        mPix = mPix + 1;
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic string strobeTag();
    string t;
    if (eZone == 5) t = "R9";
    else if (eZone == 1) t = "R5";
    else if (eZone == 0) t = "R4";
    else if (eSeqUsed == 1) t = "R6";
    else if (eSeqUsed == 2) t = "R7";
    else t = "R8";
    return {t, " ", phaseTag};
  endfunction

  task automatic checkAll();
    check(int'(shiftBlank), int'(eShift), {"R4 shiftBlank ", phaseTag});
    check(int'(dataBlank), int'(eBlank), {strobeTag(), " dataBlank"});
    check(int'(blackClamp), int'(eClamp), {strobeTag(), " blackClamp"});
    check(int'(seqCode), mSeq, {"R2 R3 seqCode ", phaseTag});
    check(int'(shiftBlank) + int'(dataBlank) + int'(blackClamp) <= 1 ? 1 : 0, 1,
          "R10 strobe exclusivity");
  endtask

  task automatic tick(input bit vs, input bit hs);
    @(negedge clk);
    if (rstN) checkAll();
    vSync = vs;
    hSync = hs;
  endtask

  task automatic runLine(input int len);
    tick(1'b0, 1'b1);
    repeat (len - 1) tick(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected below 50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values before any sync
    check(int'(shiftBlank), 0, "R1 shiftBlank after reset");
    check(int'(dataBlank), 1, "R1 dataBlank after reset");
    check(int'(blackClamp), 0, "R1 blackClamp after reset");
    check(int'(seqCode), 1, "R1 seqCode after reset");
    repeat (6) tick(1'b0, 1'b0);

    // Frame A: all regions and blanking past the frame end
    phaseTag = "frameA";
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    for (int k = 1; k <= 14; k++) runLine(30);

    // Frame B: coincident syncs, then a line cut short in the image region
    phaseTag = "R2 coincident";
    tick(1'b1, 1'b1);
    repeat (29) tick(1'b0, 1'b0);
    phaseTag = "frameB";
    for (int k = 1; k <= 6; k++) runLine(30);
    phaseTag = "R11 short line";
    runLine(15);
    runLine(30);
    phaseTag = "frameB";
    for (int k = 1; k <= 5; k++) runLine(30);
    repeat (20) tick(1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule